// File: doc/BRIEF.md
# Low-Speed USB Receive Bit Engine

This block is the bit-level front end of a low-speed USB receiver. The two data lines are sampled by a system clock that runs a fixed multiple of the line bit rate. A sampling counter is reloaded to half a bit period on every line transition, so each sample falls in the middle of a bit cell. The sampled line state is classified, NRZI-decoded, stripped of stuffed bits and assembled into bytes, least significant bit first. A serial CRC runs over the same bits.

The block waits in a hunt state until it sees the sync pattern. It then emits a sync control item and starts a packet. It delivers each completed byte with a one-cycle valid strobe. A single-ended-zero state closes the packet with an end-of-packet control item, and the CRC verdict appears in that same cycle. Line errors and bit-stuffing violations raise a one-cycle error pulse. After an error the block ignores the line until the next end-of-packet state.

Top module: `lsrx_core`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `rx_valid`, `rx_eop`, `rx_err` and `rx_crc_ok` are 0.
- R2: Line states are read as {dp_in,dm_in}: 2'b01 is J (idle), 2'b10 is K, 2'b00 is SE0 and 2'b11 is SE1. An SE1 sample gives a one-cycle `rx_err` pulse. Every later sample is then ignored until an SE0 sample, and no end-of-packet item is produced for that packet.
- R3: The bit period is the parameter PERIOD (default 64 clocks). Every line transition reloads the sampling counter so that the next sample comes half a period later. A received stream whose symbols each last anywhere from PERIOD-2 to PERIOD+2 clocks still decodes correctly.
- R4: From idle, the line sequence K J K J K J K K emits a control item (`rx_ctrl`=1, `rx_byte`=8'h01) and starts a packet. No item is emitted before that.
- R5: NRZI decoding: a J/K state equal to the previous one decodes as 1, and a change decodes as 0. The first bit after sync becomes bit 0 of the first byte. Each eighth data bit produces a data item with `rx_ctrl`=0.
- R6: A counter of consecutive 1 bits is cleared when sync is detected. The bit that follows six consecutive 1 bits is removed when it is 0: it is neither data nor a CRC input.
- R7: If that bit is a 1 instead, `rx_err` pulses for one cycle. The rest of the packet is dropped, with no end-of-packet item.
- R8: An SE0 sample inside a packet emits a control item (`rx_ctrl`=1, `rx_byte`=8'h02) and a one-cycle `rx_eop` in the same cycle. A trailing partial byte is discarded.
- R9: `crc16_sel` is captured at sync: 0 selects CRC5 (reflected polynomial 5'h14, seed 5'h1F) and 1 selects CRC16 (reflected polynomial 16'hA001, seed 16'hFFFF). For each data bit b, if b XOR crc[0] is 1 the register is shifted right and XORed with the polynomial; otherwise it is only shifted right. At end of packet, `rx_crc_ok` is 1 exactly when the register equals 5'h06 (CRC5) or 16'hB001 (CRC16). The value holds until the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, PERIOD cycles per bit |
| rst | input | 1 | Synchronous active-high reset |
| dp_in | input | 1 | D+ line level, already synchronous to clk |
| dm_in | input | 1 | D- line level, already synchronous to clk |
| crc16_sel | input | 1 | CRC kind for the next packet: 1 = CRC16, 0 = CRC5 |
| rx_byte | output | 8 | Data byte or control code |
| rx_valid | output | 1 | One-cycle strobe for an item on rx_byte |
| rx_ctrl | output | 1 | Item on rx_byte is a control code |
| rx_eop | output | 1 | One-cycle end-of-packet pulse |
| rx_err | output | 1 | One-cycle line or stuffing error pulse |
| rx_crc_ok | output | 1 | CRC residue matched at the last end of packet |

## Verification
If the sampling counter drifts, or the NRZI reference state goes stale, the bytes shift or flip at the next byte strobe. The same fault also shows one bit time later, in a wrong sync detection or a missing sync item. A wrong ones count or a lost stuff bit misaligns every byte after that point and spoils the residue, so it appears both in the data items and in `rx_crc_ok` at end of packet. A stuck state machine shows up as a missing end-of-packet item, or as items after an error.

// File: rtl/lsrx_pkg.sv
package lsrx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LN_SE0 = 2'b00,
        LN_J   = 2'b01,
        LN_K   = 2'b10,
        LN_SE1 = 2'b11
    } line_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DATA = 2'd1,
        ST_DROP = 2'd2
    } fsm_e;

    // one classified sample of the line
    typedef struct packed {
        logic valid;
        logic se0;
        logic se1;
        logic bitv;
    } bit_evt_t;

    localparam logic [BYTE_W-1:0] CTL_SYNC  = 8'h01;
    localparam logic [BYTE_W-1:0] CTL_EOP   = 8'h02;
    localparam logic [BYTE_W-1:0] SYNC_BITS = 8'h80;

    localparam logic [4:0]  POLY5   = 5'h14;
    localparam logic [15:0] POLY16  = 16'hA001;
    localparam logic [4:0]  SEED5   = 5'h1F;
    localparam logic [15:0] SEED16  = 16'hFFFF;
    localparam logic [4:0]  RESID5  = 5'h06;
    localparam logic [15:0] RESID16 = 16'hB001;

    function automatic logic [15:0] crc_step(input logic [15:0] c,
                                             input logic b,
                                             input logic w16);
        logic fb;
        logic [4:0] c5;
        fb = b ^ c[0];
        if (w16) begin
            crc_step = (c >> 1) ^ (fb ? POLY16 : 16'h0000);
        end else begin
            c5 = (c[4:0] >> 1) ^ (fb ? POLY5 : 5'h00);
            crc_step = {11'b0, c5};
        end
    endfunction

    function automatic logic crc_match(input logic [15:0] c, input logic w16);
        crc_match = w16 ? (c == RESID16) : (c[4:0] == RESID5);
    endfunction

endpackage

// File: rtl/lsrx_nco.sv
module lsrx_nco #(
    parameter int PERIOD = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_in,
    output logic       sample,
    output logic [1:0] line_smp
);
    localparam int CW   = $clog2(PERIOD);
    localparam int HALF = PERIOD / 2;
    localparam logic [CW-1:0] HALF_LD = CW'(HALF - 1);
    localparam logic [CW-1:0] FULL_LD = CW'(PERIOD - 1);

    logic [1:0]    ln_q, ln_qq;
    logic [CW-1:0] cnt;
    logic          edge_w;

    assign edge_w   = (ln_q != ln_qq);
    assign sample   = (cnt == '0) && !edge_w;
    assign line_smp = ln_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q  <= 2'b01;
            ln_qq <= 2'b01;
            cnt   <= HALF_LD;
        end else begin
            ln_q  <= line_in;
            ln_qq <= ln_q;
            if (edge_w)
                cnt <= HALF_LD;
            else if (cnt == '0)
                cnt <= FULL_LD;
            else
                cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/lsrx_nrzi.sv
module lsrx_nrzi
    import lsrx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sample,
    input  logic [1:0] line_smp,
    output bit_evt_t   evt
);
    line_e prev_jk;
    line_e cur;

    assign cur = line_e'(line_smp);

    always_comb begin
        evt.valid = sample;
        evt.se0   = (cur == LN_SE0);
        evt.se1   = (cur == LN_SE1);
        evt.bitv  = (cur == prev_jk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_jk <= LN_J;
        end else if (sample) begin
            if (cur == LN_SE0)
                prev_jk <= LN_J;
            else if (cur != LN_SE1)
                prev_jk <= cur;
        end
    end
endmodule

// File: rtl/lsrx_framer.sv
module lsrx_framer
    import lsrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bit_evt_t          evt,
    input  logic              crc16_sel,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_ctrl,
    output logic              rx_eop,
    output logic              rx_err,
    output logic              rx_crc_ok
);
    localparam int BCW = $clog2(BYTE_W);

    fsm_e              state;
    logic [BYTE_W-1:0] hunt_sr;
    logic [BYTE_W-1:0] nxt_hunt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] nxt_shreg;
    logic [2:0]        ones;
    logic [BCW-1:0]    bitcnt;
    logic [15:0]       crc;
    logic              sel_q;

    assign nxt_hunt  = {evt.bitv, hunt_sr[BYTE_W-1:1]};
    assign nxt_shreg = {evt.bitv, shreg[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            hunt_sr   <= '1;
            shreg     <= '0;
            ones      <= '0;
            bitcnt    <= '0;
            crc       <= '0;
            sel_q     <= 1'b0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            rx_ctrl   <= 1'b0;
            rx_eop    <= 1'b0;
            rx_err    <= 1'b0;
            rx_crc_ok <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_eop   <= 1'b0;
            rx_err   <= 1'b0;
            if (evt.valid) begin
                if (evt.se1) begin
                    rx_err <= 1'b1;
                    state  <= ST_DROP;
                end else begin
                    unique case (state)
                        ST_HUNT: begin
                            if (evt.se0) begin
                                hunt_sr <= '1;
                            end else begin
                                hunt_sr <= nxt_hunt;
                                if (nxt_hunt == SYNC_BITS) begin
                                    state     <= ST_DATA;
                                    ones      <= '0;
                                    bitcnt    <= '0;
                                    sel_q     <= crc16_sel;
                                    crc       <= crc16_sel ? SEED16 : {11'b0, SEED5};
                                    rx_crc_ok <= 1'b0;
                                    rx_valid  <= 1'b1;
                                    rx_ctrl   <= 1'b1;
                                    rx_byte   <= CTL_SYNC;
                                end
                            end
                        end
                        ST_DATA: begin
                            if (evt.se0) begin
                                state     <= ST_HUNT;
                                hunt_sr   <= '1;
                                rx_valid  <= 1'b1;
                                rx_ctrl   <= 1'b1;
                                rx_byte   <= CTL_EOP;
                                rx_eop    <= 1'b1;
                                rx_crc_ok <= crc_match(crc, sel_q);
                            end else if (ones == 3'd6) begin
                                if (evt.bitv) begin
                                    rx_err <= 1'b1;
                                    state  <= ST_DROP;
                                end else begin
                                    ones <= '0;
                                end
                            end else begin
                                ones   <= evt.bitv ? ones + 1'b1 : 3'd0;
                                shreg  <= nxt_shreg;
                                crc    <= crc_step(crc, evt.bitv, sel_q);
                                bitcnt <= bitcnt + 1'b1;
                                if (bitcnt == BCW'(BYTE_W - 1)) begin
                                    rx_valid <= 1'b1;
                                    rx_ctrl  <= 1'b0;
                                    rx_byte  <= nxt_shreg;
                                end
                            end
                        end
                        ST_DROP: begin
                            if (evt.se0) begin
                                state   <= ST_HUNT;
                                hunt_sr <= '1;
                            end
                        end
                        default: state <= ST_HUNT;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/lsrx_core.sv
module lsrx_core
    import lsrx_pkg::*;
#(
    parameter int PERIOD = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dp_in,
    input  logic       dm_in,
    input  logic       crc16_sel,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_ctrl,
    output logic       rx_eop,
    output logic       rx_err,
    output logic       rx_crc_ok
);
    logic       sample;
    logic [1:0] line_smp;
    bit_evt_t   evt;

    lsrx_nco #(.PERIOD(PERIOD)) u_nco (
        .clk      (clk),
        .rst      (rst),
        .line_in  ({dp_in, dm_in}),
        .sample   (sample),
        .line_smp (line_smp)
    );

    lsrx_nrzi u_nrzi (
        .clk      (clk),
        .rst      (rst),
        .sample   (sample),
        .line_smp (line_smp),
        .evt      (evt)
    );

    lsrx_framer u_framer (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .crc16_sel (crc16_sel),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .rx_ctrl   (rx_ctrl),
        .rx_eop    (rx_eop),
        .rx_err    (rx_err),
        .rx_crc_ok (rx_crc_ok)
    );
endmodule

// File: rtl/lsrx_checker.sv
module lsrx_checker (
    input logic       clk,
    input logic       rst,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_ctrl,
    input logic       rx_eop,
    input logic       rx_err,
    input logic       rx_crc_ok
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!rx_valid && !rx_eop && !rx_err && !rx_crc_ok)); // R1

    AST_EOP_ITEM: assert property (@(posedge clk) disable iff (rst)
        rx_eop |-> (rx_valid && rx_ctrl && rx_byte == 8'h02)); // R8

    AST_SYNC_ITEM: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ctrl && !rx_eop) |-> (rx_byte == 8'h01)); // R4

    AST_ERR_NO_ITEM: assert property (@(posedge clk) disable iff (rst)
        rx_err |-> !rx_valid); // R7

    AST_ITEM_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R5

    AST_CRCOK_HELD: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_ctrl) |-> $stable(rx_crc_ok)); // R9
endmodule

bind lsrx_core lsrx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .rx_ctrl   (rx_ctrl),
    .rx_eop    (rx_eop),
    .rx_err    (rx_err),
    .rx_crc_ok (rx_crc_ok)
);

// File: tb/lsrx_core_tb.sv
module lsrx_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PER = 64;
    localparam logic [1:0] SJ = 2'b01, SK = 2'b10, S0 = 2'b00, S1 = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dp_in = 1'b0, dm_in = 1'b1;
    logic crc16_sel = 1'b1;
    logic [7:0] rx_byte;
    logic rx_valid, rx_ctrl, rx_eop, rx_err, rx_crc_ok;

    int total = 0;
    int bad = 0;
    bit jit_on = 1'b0;
    logic [1:0] cur = 2'b01;

    logic [8:0] obs[$];
    logic [8:0] expq[$];
    int n_eop = 0;
    int n_err = 0;
    logic last_ok = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsrx_core #(.PERIOD(PER)) u_dut (
        .clk(clk), .rst(rst), .dp_in(dp_in), .dm_in(dm_in),
        .crc16_sel(crc16_sel), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_ctrl(rx_ctrl), .rx_eop(rx_eop), .rx_err(rx_err),
        .rx_crc_ok(rx_crc_ok)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) obs.push_back({rx_ctrl, rx_byte});
            if (rx_eop) begin
                n_eop = n_eop + 1;
                last_ok = rx_crc_ok;
            end
            if (rx_err) n_err = n_err + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic sym(input logic [1:0] s);
        int len;
        len = PER;
        if (jit_on) len = PER + int'($urandom_range(4)) - 2;
        {dp_in, dm_in} = s;
        repeat (len) @(posedge clk);
        #1;
    endtask

    // serial CRC per R9, bits taken LSB first
    function automatic logic [15:0] bcrc(input logic [63:0] bits, input int n, input bit w16);
        logic [15:0] c;
        c = w16 ? 16'hFFFF : 16'h001F;
        for (int i = 0; i < n; i++) begin
            if (w16) c = (c[0] ^ bits[i]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
            else     c = (c[0] ^ bits[i]) ? {11'b0, (c[4:0] >> 1) ^ 5'h14} : {11'b0, c[4:0] >> 1};
        end
        return c;
    endfunction

    // kind: 0 normal EOP, 1 SE1 after bits; viol skips stuffing
    task automatic send(input logic [63:0] bits, input int n, input bit viol, input int kind);
        int ones;
        obs.delete();
        n_eop = 0;
        n_err = 0;
        sym(SK); sym(SJ); sym(SK); sym(SJ); sym(SK); sym(SJ); sym(SK); sym(SK);
        cur = SK;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            if (!bits[i]) cur = ~cur;
            sym(cur);
            ones = bits[i] ? ones + 1 : 0;
            if (ones == 6 && !viol) begin
                cur = ~cur;
                sym(cur);
                ones = 0;
            end
        end
        if (kind == 1) sym(S1);
        sym(S0); sym(S0); sym(SJ); sym(SJ);
        cur = SJ;
    endtask

    task automatic build_exp(input logic [63:0] bits, input int n, input bit with_eop);
        expq.delete();
        expq.push_back({1'b1, 8'h01});
        for (int k = 0; k < n / 8; k++) expq.push_back({1'b0, bits[8*k +: 8]});
        if (with_eop) expq.push_back({1'b1, 8'h02});
    endtask

    task automatic compare_items(input string req);
        chk(obs.size() == expq.size(), req, obs.size(), expq.size());
        if (obs.size() == expq.size())
            for (int k = 0; k < expq.size(); k++)
                chk(obs[k] == expq[k], req, obs[k], expq[k]);
    endtask

    task automatic run_packet(input logic [63:0] bits, input int n, input bit w16, input string req);
        logic [15:0] res;
        bit exp_ok;
        res = bcrc(bits, n, w16);
        exp_ok = w16 ? (res == 16'hB001) : (res[4:0] == 5'h06);
        crc16_sel = w16;
        build_exp(bits, n, 1'b1);
        send(bits, n, 1'b0, 0);
        compare_items(req);
        chk(n_eop == 1, "R8 eop count", n_eop, 1);
        chk(last_ok == exp_ok, "R9 crc_ok", last_ok, exp_ok);
        chk(n_err == 0, "R2 no error", n_err, 0);
    endtask

    function automatic logic [63:0] make_data(input logic [31:0] pay, input int nb, output int n);
        logic [63:0] b;
        logic [15:0] c;
        b = 64'(pay) & ((64'd1 << (8 * nb)) - 1);
        c = bcrc(b, 8 * nb, 1'b1);
        b = b | (64'(~c) << (8 * nb));
        n = 8 * nb + 16;
        return b;
    endfunction

    function automatic logic [63:0] make_token(input logic [10:0] tk, output int n);
        logic [63:0] b;
        logic [15:0] c;
        b = 64'(tk);
        c = bcrc(b, 11, 1'b0);
        b = b | (64'(~c[4:0]) << 11);
        n = 16;
        return b;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] b;
        int n;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(rx_valid == 0, "R1 valid", rx_valid, 0);
        chk(rx_eop == 0, "R1 eop", rx_eop, 0);
        chk(rx_err == 0, "R1 err", rx_err, 0);
        chk(rx_crc_ok == 0, "R1 crc_ok", rx_crc_ok, 0);
        @(posedge clk); #1;
        sym(SJ); sym(SJ);

        // R4 R5 R8 R9: directed CRC16 packet
        b = make_data(32'h0000_A55A, 2, n);
        run_packet(b, n, 1'b1, "R5 data bytes");
        // R9 CRC5 token
        b = make_token(11'h3A5, n);
        run_packet(b, n, 1'b0, "R9 token bytes");
        // R6 long runs of ones force stuff bits
        b = make_data(32'h00FF_FFFF, 3, n);
        run_packet(b, n, 1'b1, "R6 unstuff");
        // R9 corrupted CRC gives crc_ok=0
        b = make_data(32'h0000_1234, 2, n);
        b[3] = ~b[3];
        run_packet(b, n, 1'b1, "R9 corrupt");

        // R7 stuffing violation: seven ones without stuff bit
        crc16_sel = 1'b1;
        b = 64'h0000_0000_0000_FFFF;
        expq.delete();
        expq.push_back({1'b1, 8'h01});
        send(b, 16, 1'b1, 0);
        compare_items("R7 items");
        chk(n_err == 1, "R7 err pulse", n_err, 1);
        chk(n_eop == 0, "R7 no eop", n_eop, 0);

        // R2 SE1 mid-packet
        b = 64'h0000_0000_0000_0033;
        build_exp(b, 8, 1'b0);
        send(b, 8, 1'b0, 1);
        compare_items("R2 items");
        chk(n_err == 1, "R2 err pulse", n_err, 1);
        chk(n_eop == 0, "R2 no eop", n_eop, 0);

        // R3 random packets with symbol-length jitter
        jit_on = 1'b1;
        for (int p = 0; p < 14; p++) begin
            if ($urandom_range(1) == 0) begin
                b = make_token(11'($urandom), n);
                if ($urandom_range(3) == 0) b[$urandom_range(15)] ^= 1'b1;
                run_packet(b, n, 1'b0, "R3 token");
            end else begin
                b = make_data($urandom, int'($urandom_range(3)) + 1, n);
                if ($urandom_range(3) == 0) b[$urandom_range(15)] ^= 1'b1;
                run_packet(b, n, 1'b1, "R3 data");
            end
        end
        jit_on = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule